// File: doc/BRIEF.md
# Branch Target Stream Cache

This block keeps, for recently taken branches, the first four instructions found at each branch's target. Fetch presents the target's word address on the lookup port. When the target is cached, the block answers with a hit and the four instructions, so the instruction queue can be filled one cycle earlier than a main instruction-cache access would allow. After a taken branch resolves, the fetch logic writes the target address and its four instructions through the fill port.

Storage holds 128 entries: 32 sets of four ways each. The set comes from the low word-address bits, and the remaining upper bits are stored as the tag. Within a set, replacement follows a three-bit tree pseudo-LRU. Both lookup hits and fills update it. A single input drops every entry in one cycle. The lookup path is combinational from the address into an output register, so a response appears in the cycle after its request.

Top module: `brtgt_cache`

## Requirements
- R1: After reset, rsp_valid and rsp_hit are low, and every lookup misses until a fill has written the looked-up address.
- R2: rsp_valid is high in exactly the cycles that follow a cycle with lk_req high. rsp_hit and rsp_insn belong to that same response cycle.
- R3: The address ports carry word addresses (byte address bits [31:2]). Port bits [4:0] (byte bits [6:2]) select one of 32 sets, and port bits [29:5] form the tag. Equal tags in different sets are separate entries, and so are different tags in the same set.
- R4: A hit returns exactly the 128 bits last written for that address. Instruction k of the target stream sits in bits [32k+31:32k], with k = 0 being the target instruction itself.
- R5: A fill to an address already present rewrites that entry in place and does not allocate a second copy, so the other entries of the set survive.
- R6: A fill to an absent address goes to the lowest-numbered empty way of its set if one exists, and no valid entry is evicted in that case.
- R7: When a full set takes a new fill, the victim is given by a three-bit tree. A root bit selects a pair of ways ({0,1} or {2,3}), and one bit per pair selects a way within it. Every lookup hit and every fill sets the bits on its path to point away from the way it used. In a cycle with both events in one set, the hit is applied first and then the fill. The victim is chosen from the tree as it was at the start of the cycle.
- R8: flush_all invalidates every entry in one cycle, so lookups in later cycles miss. A fill in the same cycle as flush_all is discarded.
- R9: A lookup in the same cycle as a fill or a flush sees the contents as they were before that cycle.
- R10: A response that misses drives rsp_insn to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_req | input | 1 | Lookup request this cycle |
| lk_addr | input | 30 | Word address of the branch target to look up |
| rsp_valid | output | 1 | Response to last cycle's request |
| rsp_hit | output | 1 | Response found the target |
| rsp_insn | output | 128 | Four target instructions, zero on a miss |
| fill_en | input | 1 | Write an entry this cycle |
| fill_addr | input | 30 | Word address of the target being written |
| fill_insn | input | 128 | Four instructions to store, slot 0 in the low bits |
| flush_all | input | 1 | Invalidate every entry |

## Verification
A wrong valid or tag bit shows up on the first lookup of that address, one cycle after the request, as a hit that should be a miss or the reverse. A corrupted data word shows as wrong instruction bits in that same response. A wrong replacement tree stays hidden until a full set takes a fill and evicts the wrong way. That error only appears at a later lookup of the entry that should have survived, so the bench keeps its own model of every set and checks every response against it over long conflict-heavy runs.

// File: rtl/brtgt_pkg.sv
`timescale 1ns/1ps
package brtgt_pkg;
  localparam int WAYS = 4;
  typedef logic [1:0] way_t;
  typedef logic [2:0] tree_t;   // [0] pair select, [1] left pair, [2] right pair

  function automatic way_t tree_victim(tree_t t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic tree_t tree_touch(tree_t t, way_t w);
    tree_t r;
    r    = t;
    r[0] = ~w[1];
    if (w[1]) r[2] = ~w[0];
    else      r[1] = ~w[0];
    return r;
  endfunction

  function automatic way_t oh_to_way(logic [WAYS-1:0] oh);
    way_t r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (oh[w]) r = way_t'(w);
    return r;
  endfunction

  function automatic way_t first_free(logic [WAYS-1:0] v);
    way_t r;
    r = '0;
    for (int w = WAYS - 1; w >= 0; w--) if (!v[w]) r = way_t'(w);
    return r;
  endfunction
endpackage

// File: rtl/brtgt_way.sv
`timescale 1ns/1ps
module brtgt_way #(
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 25,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  ra_idx,
  output logic              ra_valid,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output logic              rb_valid,
  output logic [TAG_W-1:0]  rb_tag
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tag_m [SETS];
  logic [DATA_W-1:0] dat_m [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   vld <= '0;
    else if (clr) vld <= '0;
    else if (we)  vld[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_m[w_idx] <= w_tag;
      dat_m[w_idx] <= w_data;
    end
  end

  assign ra_valid = vld[ra_idx];
  assign ra_tag   = tag_m[ra_idx];
  assign ra_data  = dat_m[ra_idx];
  assign rb_valid = vld[rb_idx];
  assign rb_tag   = tag_m[rb_idx];
endmodule

// File: rtl/brtgt_plru.sv
`timescale 1ns/1ps
module brtgt_plru
  import brtgt_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  way_t             a_way,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  input  way_t             b_way,
  input  logic [IDX_W-1:0] q_idx,
  output tree_t            q_tree
);
  localparam int SETS = 1 << IDX_W;

  tree_t st  [SETS];
  tree_t nxt [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_comb begin
      nxt[s] = st[s];
      if (a_en && a_idx == IDX_W'(s)) nxt[s] = tree_touch(nxt[s], a_way);
      if (b_en && b_idx == IDX_W'(s)) nxt[s] = tree_touch(nxt[s], b_way);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[s] <= '0;
      else        st[s] <= nxt[s];
    end
  end

  assign q_tree = st[q_idx];
endmodule

// File: rtl/brtgt_cache.sv
`timescale 1ns/1ps
module brtgt_cache
  import brtgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int SLOTS  = 4,
  parameter int SETS   = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_req,
  input  logic [ADDR_W-1:2]         lk_addr,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [SLOTS*INSN_W-1:0]   rsp_insn,
  input  logic                      fill_en,
  input  logic [ADDR_W-1:2]         fill_addr,
  input  logic [SLOTS*INSN_W-1:0]   fill_insn,
  input  logic                      flush_all
);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - 2 - IDX_W;
  localparam int DATA_W = SLOTS * INSN_W;

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag, fill_tag;
  assign lk_idx   = lk_addr[IDX_W+1:2];
  assign lk_tag   = lk_addr[ADDR_W-1:IDX_W+2];
  assign fill_idx = fill_addr[IDX_W+1:2];
  assign fill_tag = fill_addr[ADDR_W-1:IDX_W+2];

  logic              a_valid [WAYS];
  logic [TAG_W-1:0]  a_tag   [WAYS];
  logic [DATA_W-1:0] a_data  [WAYS];
  logic              b_valid [WAYS];
  logic [TAG_W-1:0]  b_tag   [WAYS];

  // Internal events, named for the checker
  logic [WAYS-1:0] lk_match_vec, fill_match_vec, fill_valid_vec, fill_way_oh;
  logic            lk_hit_now, fill_do;
  way_t            lk_way, fill_way;
  tree_t           fill_tree;

  assign fill_do = fill_en & ~flush_all;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    brtgt_way #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_way (
      .clk(clk), .rst_n(rst_n), .clr(flush_all),
      .we(fill_do & fill_way_oh[w]), .w_idx(fill_idx), .w_tag(fill_tag), .w_data(fill_insn),
      .ra_idx(lk_idx), .ra_valid(a_valid[w]), .ra_tag(a_tag[w]), .ra_data(a_data[w]),
      .rb_idx(fill_idx), .rb_valid(b_valid[w]), .rb_tag(b_tag[w])
    );
    assign lk_match_vec[w]   = a_valid[w] && (a_tag[w] == lk_tag);
    assign fill_match_vec[w] = b_valid[w] && (b_tag[w] == fill_tag);
    assign fill_valid_vec[w] = b_valid[w];
  end

  assign lk_hit_now = lk_req & (|lk_match_vec);
  assign lk_way     = oh_to_way(lk_match_vec);

  always_comb begin
    if (|fill_match_vec)       fill_way = oh_to_way(fill_match_vec);
    else if (~&fill_valid_vec) fill_way = first_free(fill_valid_vec);
    else                       fill_way = tree_victim(fill_tree);
    fill_way_oh = '0;
    fill_way_oh[fill_way] = fill_en;
  end

  brtgt_plru #(.IDX_W(IDX_W)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .a_en(lk_hit_now), .a_idx(lk_idx), .a_way(lk_way),
    .b_en(fill_do), .b_idx(fill_idx), .b_way(fill_way),
    .q_idx(fill_idx), .q_tree(fill_tree)
  );

  logic [DATA_W-1:0] lk_data_sel;
  always_comb begin
    lk_data_sel = '0;
    for (int w = 0; w < WAYS; w++) if (lk_match_vec[w]) lk_data_sel |= a_data[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_insn  <= '0;
    end else begin
      rsp_valid <= lk_req;
      rsp_hit   <= lk_hit_now;
      rsp_insn  <= lk_hit_now ? lk_data_sel : '0;
    end
  end
endmodule

// File: rtl/brtgt_cache_chk.sv
`timescale 1ns/1ps
module brtgt_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128,
  parameter int WAYS   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_req,
  input logic [ADDR_W-1:2] lk_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_insn,
  input logic              fill_en,
  input logic [ADDR_W-1:2] fill_addr,
  input logic [DATA_W-1:0] fill_insn,
  input logic              flush_all,
  input logic [WAYS-1:0]   lk_match_vec,
  input logic [WAYS-1:0]   fill_match_vec,
  input logic [WAYS-1:0]   fill_way_oh
);
  a_r2_req_gives_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);
  a_r2_idle_no_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);
  a_r2_hit_in_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_valid);
  a_r10_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_insn == '0));
  a_r5_one_lookup_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match_vec));
  a_r5_one_fill_copy: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_match_vec));
  a_r6_fill_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> $onehot(fill_way_oh));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && $past(flush_all)) |=> !rsp_hit);
  a_r4_fill_then_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && $past(fill_en && !flush_all) && lk_addr == $past(fill_addr))
      |=> (rsp_hit && rsp_insn == $past(fill_insn, 2)));
endmodule

bind brtgt_cache brtgt_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(brtgt_pkg::WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_insn(rsp_insn),
  .fill_en(fill_en), .fill_addr(fill_addr), .fill_insn(fill_insn), .flush_all(flush_all),
  .lk_match_vec(lk_match_vec), .fill_match_vec(fill_match_vec), .fill_way_oh(fill_way_oh)
);

// File: tb/brtgt_cache_test.sv
`timescale 1ns/1ps
module brtgt_cache_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lk_req = 1'b0;
  logic [31:2]  lk_addr = '0;
  logic         rsp_valid, rsp_hit;
  logic [127:0] rsp_insn;
  logic         fill_en = 1'b0;
  logic [31:2]  fill_addr = '0;
  logic [127:0] fill_insn = '0;
  logic         flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  brtgt_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_insn(rsp_insn),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_insn(fill_insn), .flush_all(flush_all)
  );

  // Reference model: per set, four ways and a three-bit replacement tree
  bit           m_v [32][4];
  logic [24:0]  m_t [32][4];
  logic [127:0] m_d [32][4];
  logic [2:0]   m_p [32];

  function automatic int ref_victim(logic [2:0] p);
    int pair_base;
    pair_base = p[0] ? 2 : 0;
    return pair_base + (p[0] ? int'(p[2]) : int'(p[1]));
  endfunction

  function automatic logic [2:0] ref_touch(logic [2:0] p, int w);
    logic [2:0] r;
    r = p;
    r[0] = (w < 2);
    if (w < 2) r[1] = (w == 0);
    else       r[2] = (w == 2);
    return r;
  endfunction

  task automatic chk(bit ok, string tg, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic step(bit rq, logic [29:0] la, bit fe, logic [29:0] fa,
                      logic [127:0] fd, bit fl, string tg);
    int s, fs, ew, fw, fr;
    bit eh;
    logic [127:0] ed;
    lk_req = rq; lk_addr = la; fill_en = fe; fill_addr = fa; fill_insn = fd; flush_all = fl;
    s = int'(la[4:0]); eh = 0; ew = 0; ed = '0;
    for (int w = 0; w < 4; w++)
      if (m_v[s][w] && m_t[s][w] == la[29:5]) begin eh = 1; ew = w; ed = m_d[s][w]; end
    if (!rq) eh = 0;
    if (!eh) ed = '0;
    fs = int'(fa[4:0]); fw = -1; fr = -1;
    for (int w = 0; w < 4; w++) if (m_v[fs][w] && m_t[fs][w] == fa[29:5]) fw = w;
    for (int w = 3; w >= 0; w--) if (!m_v[fs][w]) fr = w;
    if (fw < 0) fw = (fr >= 0) ? fr : ref_victim(m_p[fs]);
    if (eh) m_p[s] = ref_touch(m_p[s], ew);
    if (fe && !fl) begin
      m_v[fs][fw] = 1; m_t[fs][fw] = fa[29:5]; m_d[fs][fw] = fd;
      m_p[fs] = ref_touch(m_p[fs], fw);
    end
    if (fl) for (int i = 0; i < 32; i++) for (int w = 0; w < 4; w++) m_v[i][w] = 0;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == rq, "R2", 128'(rsp_valid), 128'(rq));
    if (rq) begin
      chk(rsp_hit == eh, tg, 128'(rsp_hit), 128'(eh));
      chk(rsp_insn == ed, eh ? "R4" : "R10", rsp_insn, ed);
    end
    lk_req = 0; fill_en = 0; flush_all = 0;
  endtask

  function automatic logic [29:0] wa(int tag, int set);
    return {25'(tag), 5'(set)};
  endfunction

  function automatic logic [127:0] dat(int k);
    return {32'(k * 4 + 3), 32'(k * 4 + 2), 32'(k * 4 + 1), 32'(k * 4) ^ 32'hA5000000};
  endfunction

  task automatic look(logic [29:0] a, string tg);
    step(1, a, 0, '0, '0, 0, tg);
  endtask

  task automatic fill(logic [29:0] a, logic [127:0] d);
    step(0, '0, 1, a, d, 0, "R2");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_p[i] = '0;
      for (int w = 0; w < 4; w++) begin m_v[i][w] = 0; m_t[i][w] = '0; m_d[i][w] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(rsp_valid == 0, "R1", 128'(rsp_valid), 0);
    chk(rsp_hit == 0, "R1", 128'(rsp_hit), 0);
    for (int s = 0; s < 32; s += 7) look(wa(s + 1, s), "R1");

    // R9: lookup in the fill cycle sees old contents, next cycle hits
    step(1, wa(5, 3), 1, wa(5, 3), dat(1), 0, "R9");
    look(wa(5, 3), "R4");

    // R3: same tag in other set, other tag in same set
    look(wa(5, 4), "R3");
    look(wa(6, 3), "R3");
    fill(wa(5, 4), dat(2));
    look(wa(5, 4), "R3");
    look(wa(5, 3), "R3");

    // R6: four distinct tags fill an empty set without eviction
    for (int t = 0; t < 4; t++) fill(wa(t + 10, 9), dat(t + 10));
    for (int t = 0; t < 4; t++) look(wa(t + 10, 9), "R6");

    // R7: fifth tag evicts the tree's victim; all five probed
    fill(wa(14, 9), dat(14));
    for (int t = 0; t < 5; t++) look(wa(t + 10, 9), "R7");
    fill(wa(15, 9), dat(15));
    for (int t = 0; t < 6; t++) look(wa(t + 10, 9), "R7");

    // R5: refill of a present address keeps the set intact
    for (int t = 0; t < 4; t++) fill(wa(t + 20, 12), dat(t + 20));
    fill(wa(21, 12), dat(99));
    fill(wa(22, 12), dat(98));
    for (int t = 0; t < 4; t++) look(wa(t + 20, 12), "R5");

    // R8: flush empties; fill in a flush cycle is dropped
    step(1, wa(20, 12), 0, '0, '0, 1, "R9");
    look(wa(20, 12), "R8");
    look(wa(5, 3), "R8");
    step(0, '0, 1, wa(30, 1), dat(30), 1, "R8");
    look(wa(30, 1), "R8");

    // Conflict-heavy sweep: few tags over few sets, every response checked
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      step(r < 70, wa(int'($urandom_range(0, 5)), int'($urandom_range(0, 3))),
           r >= 30, wa(int'($urandom_range(0, 5)), int'($urandom_range(0, 3))),
           {$urandom, $urandom, $urandom, $urandom}, r == 99, "R7");
    end
    finish_run();
  end
endmodule